// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block sits beside a two-port shared memory and works out who gets a contested location. Each port gives an active-low enable and an address. If both ports are enabled on the same address, the arbiter grants the location to the port that arrived first. It then pulls the busy flag of the other port low. The caller uses that flag to stall the losing access.

The decision looks only at enables and addresses. Whether an access is a read or a write plays no part. The inputs are sampled on every rising clock edge. A port has "arrived first" if, on the previous edge, it was already enabled at the same address it shows now, and the other port was not. When both ports arrive on the same edge, the left port wins, so the result can be reproduced. Once a grant is made it holds until the contention ends.

For each port the arbiter also drives a write-block qualifier. The memory array uses it to drop writes from that port while the port's own busy flag is low. The memory array and the data paths are not part of this block.

Top module: `dp_contention_arbiter`

## Requirements
- R1: While `rst_n` is low at a rising edge, the grant is cleared. After that edge both busy outputs are high and both write-block outputs are low.
- R2: A busy output goes low only after an edge at which both enables were low and both addresses were equal. Different addresses, or either enable high, leave both busy outputs high.
- R3: `left_busy_n` and `right_busy_n` are never low at the same time.
- R4: Contention is first sampled at some edge. If, at that edge, only one port was stable (it was also enabled at the same address on the edge before), that port wins. After that edge the other port's busy output is low.
- R5: If neither port, or both, was stable at the first contended edge, the left port wins and `right_busy_n` goes low.
- R6: While contention persists, the grant does not move. This holds even if the losing port becomes stable.
- R7: After the first edge at which contention is no longer sampled, both busy outputs are high. Contention can end through an address change, through the winner's enable going high, or through the loser's enable going high.
- R8: Each port's write-block output is high exactly while that port's own busy output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| left_en_n | input | 1 | Left port enable, active low |
| left_addr | input | ADDR_W | Left port address |
| right_en_n | input | 1 | Right port enable, active low |
| right_addr | input | ADDR_W | Right port address |
| left_busy_n | output | 1 | Busy flag to the left port, active low |
| right_busy_n | output | 1 | Busy flag to the right port, active low |
| left_wr_block | output | 1 | Internal write inhibit for the left port |
| right_wr_block | output | 1 | Internal write inhibit for the right port |

## Verification
The bench builds the arbiter with the default 11-bit address width. This lets it drive contention at the lowest address and at the all-ones address. It also exercises near misses that differ only in the top bit, which checks that the full-width compare covers every bit. Arrival order is set on the clock edges: right first, left first, same edge, and one port sliding onto an address the other already holds. A reset is applied in the middle of a contention to check that the grant is rebuilt from cleared history.

// File: rtl/dpa_pkg.sv
// Shared types for the dual-port contention arbiter.
// Assumes two ports only; the grant names which port holds the location.
package dpa_pkg;
    typedef enum logic [1:0] {
        GRANT_NONE  = 2'b00,
        GRANT_LEFT  = 2'b01,
        GRANT_RIGHT = 2'b10
    } grant_t;
endpackage

// File: rtl/dpa_port_track.sv
// Remembers one port's enable and address from the previous edge.
// Reports whether the port is settled: it is enabled now and was enabled
// at the same address on the previous edge.
// Assumes synchronous active-low reset; after reset no port counts as settled.
module dpa_port_track #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              settled
);
    logic              prev_en_n;
    logic [ADDR_W-1:0] prev_addr;

    // Capture the last sampled enable and address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_en_n <= 1'b1;
            prev_addr <= '0;
        end else begin
            prev_en_n <= en_n;
            prev_addr <= addr;
        end
    end

    // Settled when the current request repeats the previous one.
    always_comb begin
        settled = !en_n && !prev_en_n && (addr == prev_addr);
    end
endmodule

// File: rtl/dpa_match.sv
// Detects contention: both ports are enabled on the same address.
// Read or write direction is not an input here on purpose.
module dpa_match #(
    parameter int ADDR_W = 11
) (
    input  logic              left_en_n,
    input  logic [ADDR_W-1:0] left_addr,
    input  logic              right_en_n,
    input  logic [ADDR_W-1:0] right_addr,
    output logic              clash
);
    // Full-width equality, qualified by both enables.
    always_comb begin
        clash = !left_en_n && !right_en_n && (left_addr == right_addr);
    end
endmodule

// File: rtl/dpa_grant_fsm.sv
// Holds the grant for a contended location.
// A new grant goes to the only settled port; a tie goes to the left port.
// An existing grant is kept while the clash lasts, and cleared when it ends.
module dpa_grant_fsm
    import dpa_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clash,
    input  logic   left_settled,
    input  logic   right_settled,
    output grant_t grant
);
    grant_t grant_nxt;

    // Choose the next grant from the clash and the arrival order.
    always_comb begin
        grant_nxt = grant;
        if (!clash) begin
            grant_nxt = GRANT_NONE;
        end else if (grant == GRANT_NONE) begin
            if (right_settled && !left_settled) grant_nxt = GRANT_RIGHT;
            else                                grant_nxt = GRANT_LEFT;
        end
    end

    // Register the grant.
    always_ff @(posedge clk) begin
        if (!rst_n) grant <= GRANT_NONE;
        else        grant <= grant_nxt;
    end

    // R6
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != GRANT_NONE && clash) |=> (grant == $past(grant)));

    // R7
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clash |=> (grant == GRANT_NONE));
endmodule

// File: rtl/dp_contention_arbiter.sv
// Top of the dual-port contention arbiter.
// Tracks both ports, detects same-address contention, holds the grant, and
// drives an active-low busy flag and a write-block qualifier to the loser.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module dp_contention_arbiter
    import dpa_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              left_en_n,
    input  logic [ADDR_W-1:0] left_addr,
    input  logic              right_en_n,
    input  logic [ADDR_W-1:0] right_addr,
    output logic              left_busy_n,
    output logic              right_busy_n,
    output logic              left_wr_block,
    output logic              right_wr_block
);
    localparam int NPORT = 2;

    logic [NPORT-1:0]  en_v;
    logic [ADDR_W-1:0] addr_v [NPORT];
    logic [NPORT-1:0]  settled_v;
    logic              clash;
    grant_t            grant;

    // Collect the port inputs into arrays (index 0 = left, 1 = right).
    always_comb begin
        en_v[0]   = left_en_n;
        en_v[1]   = right_en_n;
        addr_v[0] = left_addr;
        addr_v[1] = right_addr;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_track
        dpa_port_track #(.ADDR_W(ADDR_W)) u_track (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_n    (en_v[p]),
            .addr    (addr_v[p]),
            .settled (settled_v[p])
        );
    end

    dpa_match #(.ADDR_W(ADDR_W)) u_match (
        .left_en_n  (left_en_n),
        .left_addr  (left_addr),
        .right_en_n (right_en_n),
        .right_addr (right_addr),
        .clash      (clash)
    );

    dpa_grant_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .clash         (clash),
        .left_settled  (settled_v[0]),
        .right_settled (settled_v[1]),
        .grant         (grant)
    );

    // Decode the grant into busy flags and write-block qualifiers.
    always_comb begin
        left_busy_n    = (grant != GRANT_RIGHT);
        right_busy_n   = (grant != GRANT_LEFT);
        left_wr_block  = (grant == GRANT_RIGHT);
        right_wr_block = (grant == GRANT_LEFT);
    end

    // R3
    busy_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!left_busy_n && !right_busy_n));

    // R2
    busy_needs_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!left_busy_n || !right_busy_n) |->
            $past(!left_en_n && !right_en_n && (left_addr == right_addr)));
endmodule

// File: tb/dp_contention_arbiter_test.sv
module dp_contention_arbiter_test;
    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          l_en_n = 1'b1, r_en_n = 1'b1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic          l_busy_n, r_busy_n, l_blk, r_blk;
    int            errors = 0;
    int            checks = 0;
    bit            done = 1'b0;

    always #2 clk = ~clk;

    dp_contention_arbiter #(.ADDR_W(AW)) uut (
        .clk (clk), .rst_n (rst_n),
        .left_en_n (l_en_n), .left_addr (l_addr),
        .right_en_n (r_en_n), .right_addr (r_addr),
        .left_busy_n (l_busy_n), .right_busy_n (r_busy_n),
        .left_wr_block (l_blk), .right_wr_block (r_blk)
    );

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: {lbusy,rbusy,lblk,rblk} got %b expected %b", req, got, exp);
        end
    endtask

    // Expected output vector for a given owner: 0 none, 1 left wins, 2 right wins.
    function automatic logic [3:0] expect_for(input int owner);
        case (owner)
            1:       return 4'b1001;
            2:       return 4'b0110;
            default: return 4'b1100;
        endcase
    endfunction

    function automatic logic [3:0] outs();
        return {l_busy_n, r_busy_n, l_blk, r_blk};
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_ports(input logic le, input logic [AW-1:0] la,
                             input logic re, input logic [AW-1:0] ra);
        l_en_n = le; l_addr = la; r_en_n = re; r_addr = ra;
    endtask

    task automatic idle();
        set_ports(1'b1, '0, 1'b1, '0);
        step();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        set_ports(1'b0, 11'h123, 1'b0, 11'h123);
        step(); step();
        check("R1 reset state", outs(), expect_for(0));
        rst_n = 1'b1;
        idle();
    endtask

    task automatic t_no_match();
        set_ports(1'b0, 11'h000, 1'b0, 11'h400);
        step();
        check("R2 top-bit mismatch", outs(), expect_for(0));
        set_ports(1'b0, 11'h2A5, 1'b1, 11'h2A5);
        step();
        check("R2 right disabled", outs(), expect_for(0));
        set_ports(1'b1, 11'h2A5, 1'b0, 11'h2A5);
        step();
        check("R2 left disabled", outs(), expect_for(0));
        idle();
    endtask

    task automatic t_right_first();
        set_ports(1'b1, 11'h000, 1'b0, 11'h055);
        step();
        set_ports(1'b0, 11'h055, 1'b0, 11'h055);
        step();
        check("R4 right first, left busy", outs(), expect_for(2));
        check("R8 left write blocked", {l_blk, r_blk, 2'b00}, 4'b1000);
        for (int i = 0; i < 3; i++) begin
            step();
            check("R6 right grant held", outs(), expect_for(2));
            check("R3 busy exclusive", {1'b0, (l_busy_n | r_busy_n), 2'b00}, 4'b0100);
        end
        set_ports(1'b1, 11'h055, 1'b0, 11'h055);
        step();
        check("R7 loser disables", outs(), expect_for(0));
        idle();
    endtask

    task automatic t_left_first();
        set_ports(1'b0, 11'h7FF, 1'b1, 11'h000);
        step();
        set_ports(1'b0, 11'h7FF, 1'b0, 11'h7FF);
        step();
        check("R4 left first, right busy", outs(), expect_for(1));
        set_ports(1'b1, 11'h7FF, 1'b0, 11'h7FF);
        step();
        check("R7 winner disables", outs(), expect_for(0));
        idle();
    endtask

    task automatic t_slide();
        set_ports(1'b0, 11'h100, 1'b0, 11'h101);
        step();
        check("R2 adjacent addresses", outs(), expect_for(0));
        set_ports(1'b0, 11'h101, 1'b0, 11'h101);
        step();
        check("R4 left slides onto settled right", outs(), expect_for(2));
        set_ports(1'b0, 11'h101, 1'b0, 11'h102);
        step();
        check("R7 address change releases", outs(), expect_for(0));
        idle();
    endtask

    task automatic t_tie();
        set_ports(1'b0, 11'h000, 1'b0, 11'h000);
        step();
        check("R5 same-edge tie to left", outs(), expect_for(1));
        step(); step();
        check("R6 both settled, left keeps grant", outs(), expect_for(1));
        idle();
        check("R7 both disabled", outs(), expect_for(0));
    endtask

    task automatic t_reset_mid();
        set_ports(1'b1, 11'h000, 1'b0, 11'h3C3);
        step();
        set_ports(1'b0, 11'h3C3, 1'b0, 11'h3C3);
        step();
        check("R4 right grant before reset", outs(), expect_for(2));
        rst_n = 1'b0;
        step();
        check("R1 reset during clash", outs(), expect_for(0));
        rst_n = 1'b1;
        step();
        check("R5 no history after reset, left wins", outs(), expect_for(1));
        idle();
    endtask

    initial begin
        step();
        t_reset();
        t_no_match();
        t_right_first();
        t_left_first();
        t_slide();
        t_tie();
        t_reset_mid();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule